// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Block

This block is the software-visible register set of an Ethernet MAC. A host reaches it through a simple 32-bit request/response bus addressed by word offset. It holds the operating mode, the station address, the multicast hash filter, flow control, two VLAN tags, the wake-up filter set, system control and status, and the receive and transmit status, sticky and interrupt-enable words. It also holds the statistics-unit control word and that unit's interrupt status and enable words. The frame datapaths, the PHY and any timestamp logic sit outside. They report events through set inputs and use the configuration outputs.

Every register has its own write rule. Some are plain storage. Some clear only the bits written with one, within a per-register mask. The two frame status words ignore writes. The mode word clears the completion flags when an enable bit rises. The statistics control word has a bit that pulses a counter-clear strobe and always reads back as zero. A write to the management address word starts a PHY management operation through a start/done handshake with an external station-management engine. A busy bit stays set until that engine answers.

Each request is answered one cycle later with the register's value and two error flags. Only word-sized accesses (size code 2'b10) are accepted. Offsets 0 to 31 hold registers. Every other offset is unmapped.

Top module: `emac_csr_top`

## Requirements
- R1: A request whose size code is not 2'b10 raises rsp_err_size_o with rsp_valid_o one cycle later. It returns zero read data, changes no register, and never raises rsp_err_map_o, even when the offset is also unmapped.
- R2: A word-sized request to an offset of 32 or more raises rsp_err_map_o for one cycle. It returns zero read data and changes no register.
- R3: Every request gets rsp_valid_o in the following cycle. A read returns the register value held before that cycle's update. A write returns zero read data. The plain registers read back exactly what was written (hash words at offsets 3 and 4, flow word at 7, system control at 19, enables at 23, 26, 29, 31).
- R4: After reset the address-low word (offset 1) is 0xFFFFFFFF. The address-high word (2) and both VLAN words (8, 9) are 0x0000FFFF. System control (19) is 0x00003F00 and statistics control (27) is 0x0000000A. Every other register is 0.
- R5: A write to the mode word (offset 0) that takes bit 0 from 0 to 1 clears bit 0 of the RX status word (21). One that takes bit 1 from 0 to 1 clears bit 0 of the TX status word (24). A write that leaves an enable bit at 1 clears nothing.
- R6: In the wake-up control word (offset 10), bits within mask 0xF20 are cleared by writing one and otherwise keep their value. All other bits take the written value.
- R7: In the system status word (offset 20), bits within mask 0x0E1 are cleared by writing one. Writes never change any other bit.
- R8: Writes to the RX status (21) and TX status (24) words are ignored. Bits given on rx_evt_i or tx_evt_i are set in the matching status word and in its sticky word (22 or 25).
- R9: The RX sticky (22), TX sticky (25) and both statistics interrupt status words (28 for RX, 30 for TX) clear any bit written with one. An event bit arriving in the same cycle as its clear wins and stays set.
- R10: Writing the statistics control word (27) with bit 0 set pulses counters_clear_o for exactly one cycle, in the cycle after the write. Bit 0 always reads as 0, and the other bits are stored.
- R11: When not busy, a write to the management address word (offset 5) stores the value with busy (bit 0) set. It pulses sta_start_o in the next cycle, with op bit 1 (1 = PHY write) on sta_write_o, bits [6:2] on sta_reg_o, bits [11:7] on sta_phy_o and the low 16 bits of the data word (6) on sta_wdata_o. Busy holds until sta_done_i. Writes to words 5 and 6 are ignored while busy.
- R12: When sta_done_i ends a read operation, the data word is loaded with sta_rdata_i, or with 0x0000FFFF when sta_nophy_i is high. When it ends a write operation, the data word is left unchanged.
- R13: mode_o, mac_addr_o ({address-high[15:0], address-low}), hash_o ({word 4, word 3}), flow_o, vlan_a_o, vlan_b_o and sys_ctl_o always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (6) | Word offset |
| req_size_i | input | SIZE_W (2) | Access size code, 2'b10 = 32-bit |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_size_o | output | 1 | Wrong access size |
| rsp_err_map_o | output | 1 | Unmapped offset |
| rx_evt_i | input | 32 | RX status bits to set |
| tx_evt_i | input | 32 | TX status bits to set |
| sys_evt_i | input | 32 | System status bits to set |
| wake_evt_i | input | 32 | Wake-up control bits to set |
| mmc_rx_evt_i | input | 32 | Statistics RX interrupt bits to set |
| mmc_tx_evt_i | input | 32 | Statistics TX interrupt bits to set |
| sta_start_o | output | 1 | Management operation start pulse |
| sta_write_o | output | 1 | Operation is a PHY write |
| sta_phy_o | output | 5 | PHY address |
| sta_reg_o | output | 5 | PHY register address |
| sta_wdata_o | output | 16 | PHY write data |
| sta_done_i | input | 1 | Management operation finished |
| sta_rdata_i | input | 16 | PHY read data |
| sta_nophy_i | input | 1 | No PHY answered the read |
| mode_o | output | 32 | Mode word |
| mac_addr_o | output | 48 | Station address |
| hash_o | output | 64 | Hash filter |
| flow_o | output | 32 | Flow control word |
| vlan_a_o | output | 16 | First VLAN tag |
| vlan_b_o | output | 16 | Second VLAN tag |
| sys_ctl_o | output | 32 | System control word |
| counters_clear_o | output | 1 | Statistics counter clear pulse |

## Verification
Assertions check on every cycle the properties that follow from a single earlier cycle. These are the error flags and zero data for bad size or unmapped offsets, the completion-flag clear on a rising enable, and the counter-clear strobe after a bit-0 write. They also cover the set-over-clear priority in the clear-by-one words, the busy bit holding until done, and the all-ones load on a read with no PHY. A reference model in the bench tracks every register and is compared with every output on every clock. The directed scenarios are the only place to show the masked mixtures of plain and clear-by-one bits, ignored writes to the status words and during busy, the reset image, and full management sequences through a stub engine.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 5;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int STA_W    = 16;
  localparam int PHY_W    = 5;
  localparam int PREG_W   = 5;

  localparam int RG_MODE      = 0;
  localparam int RG_ADDR_LO   = 1;
  localparam int RG_ADDR_HI   = 2;
  localparam int RG_HASH_LO   = 3;
  localparam int RG_HASH_HI   = 4;
  localparam int RG_MG_ADDR   = 5;
  localparam int RG_MG_DATA   = 6;
  localparam int RG_FLOW      = 7;
  localparam int RG_VLAN_A    = 8;
  localparam int RG_VLAN_B    = 9;
  localparam int RG_WAKE_CTL  = 10;
  localparam int RG_SYS_CTL   = 19;
  localparam int RG_SYS_STAT  = 20;
  localparam int RG_RX_STAT   = 21;
  localparam int RG_RX_STKY   = 22;
  localparam int RG_TX_STAT   = 24;
  localparam int RG_TX_STKY   = 25;
  localparam int RG_MMC_CTL   = 27;
  localparam int RG_MMC_RIRQS = 28;
  localparam int RG_MMC_TIRQS = 30;

  localparam int MODE_RX_BIT = 0;
  localparam int MODE_TX_BIT = 1;
  localparam int COMP_BIT    = 0;
  localparam int MG_BUSY_BIT = 0;
  localparam int MG_OP_BIT   = 1;
  localparam int MG_REG_LSB  = 2;
  localparam int MG_PHY_LSB  = 7;

  typedef enum logic [1:0] { K_PLAIN, K_W1C, K_SPECIAL } reg_kind_e;

  function automatic reg_kind_e kind_of(int i);
    case (i)
      RG_RX_STAT, RG_TX_STAT, RG_MG_ADDR, RG_MG_DATA: return K_SPECIAL;
      RG_WAKE_CTL, RG_SYS_STAT, RG_RX_STKY, RG_TX_STKY,
      RG_MMC_RIRQS, RG_MMC_TIRQS:                     return K_W1C;
      default:                                        return K_PLAIN;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_value(int i);
    case (i)
      RG_ADDR_LO:                        return 32'hFFFF_FFFF;
      RG_ADDR_HI, RG_VLAN_A, RG_VLAN_B:  return 32'h0000_FFFF;
      RG_SYS_CTL:                        return 32'h0000_3F00;
      RG_MMC_CTL:                        return 32'h0000_000A;
      default:                           return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] store_mask(int i);
    return (i == RG_MMC_CTL) ? ~32'h1 : '1;
  endfunction

  function automatic logic [DATA_W-1:0] clear_mask(int i);
    case (i)
      RG_WAKE_CTL: return 32'h0000_0F20;
      RG_SYS_STAT: return 32'h0000_00E1;
      default:     return '1;
    endcase
  endfunction

  function automatic bit others_writable(int i);
    return i == RG_WAKE_CTL;
  endfunction
endpackage

// File: rtl/emac_csr_decode.sv
module emac_csr_decode
  import emac_csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SIZE_W = 2,
  parameter logic [SIZE_W-1:0] WORD_SIZE = SIZE_W'(2)
) (
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              size_bad_o,
  output logic              map_bad_o
);
  logic upper_set;

  generate
    if (ADDR_W > IDX_W) begin : g_upper
      assign upper_set = |req_addr_i[ADDR_W-1:IDX_W];
    end else begin : g_no_upper
      assign upper_set = 1'b0;
    end
  endgenerate

  assign idx_o      = req_addr_i[IDX_W-1:0];
  assign size_bad_o = req_valid_i && (req_size_i != WORD_SIZE);
  assign map_bad_o  = req_valid_i && !size_bad_o && upper_set;
  assign rd_ok_o    = req_valid_i && !size_bad_o && !upper_set && !req_write_i;
  assign wr_ok_o    = req_valid_i && !size_bad_o && !upper_set && req_write_i;
endmodule

// File: rtl/emac_csr_w1c_reg.sv
module emac_csr_w1c_reg #(
  parameter int              W            = 32,
  parameter logic [W-1:0]    CLR_MASK     = '1,
  parameter bit              PLAIN_OTHERS = 1'b0,
  parameter logic [W-1:0]    RST_VAL      = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, nxt;

  always_comb begin
    nxt = q_r;
    if (we_i) begin
      nxt = q_r & CLR_MASK & ~wdata_i;
      if (PLAIN_OTHERS) nxt = nxt | (wdata_i & ~CLR_MASK);
      else              nxt = nxt | (q_r & ~CLR_MASK);
    end
    nxt = nxt | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= RST_VAL;
    else     q_r <= nxt;
  end

  assign q_o = q_r;

  // R9: an event bit survives a clear in the same cycle
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((q_r & $past(set_i)) == $past(set_i)));

  // R9: with no event, written-one bits inside the mask end up clear
  assert_clear_by_one_R9: assert property (@(posedge clk) disable iff (rst)
    (we_i && set_i == '0) |=> ((q_r & $past(wdata_i) & CLR_MASK) == '0));
endmodule

// File: rtl/emac_csr_mgmt.sv
module emac_csr_mgmt
  import emac_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sta_done_i,
  input  logic [STA_W-1:0]  sta_rdata_i,
  input  logic              sta_nophy_i,
  output logic [DATA_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] data_q_o,
  output logic              sta_start_o,
  output logic              sta_write_o,
  output logic [PHY_W-1:0]  sta_phy_o,
  output logic [PREG_W-1:0] sta_reg_o,
  output logic [STA_W-1:0]  sta_wdata_o
);
  logic [DATA_W-1:0] addr_q, data_q;
  logic              start_q;
  wire               busy = addr_q[MG_BUSY_BIT];
  localparam logic [DATA_W-1:0] NO_PHY_WORD = DATA_W'({STA_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      data_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (!busy) begin
        if (addr_we_i) begin
          addr_q              <= wdata_i;
          addr_q[MG_BUSY_BIT] <= 1'b1;
          start_q             <= 1'b1;
        end else if (data_we_i) begin
          data_q <= wdata_i;
        end
      end else if (sta_done_i) begin
        addr_q[MG_BUSY_BIT] <= 1'b0;
        if (!addr_q[MG_OP_BIT])
          data_q <= sta_nophy_i ? NO_PHY_WORD : DATA_W'(sta_rdata_i);
      end
    end
  end

  assign addr_q_o    = addr_q;
  assign data_q_o    = data_q;
  assign sta_start_o = start_q;
  assign sta_write_o = addr_q[MG_OP_BIT];
  assign sta_phy_o   = addr_q[MG_PHY_LSB +: PHY_W];
  assign sta_reg_o   = addr_q[MG_REG_LSB +: PREG_W];
  assign sta_wdata_o = data_q[STA_W-1:0];

  // R11: start only ever pulses with busy already set
  assert_start_busy_R11: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy);

  // R11: busy holds until the engine answers
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !sta_done_i) |=> busy);

  // R12: an unanswered read loads all ones
  assert_nophy_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && sta_done_i && !addr_q[MG_OP_BIT] && sta_nophy_i) |=> (data_q == NO_PHY_WORD));
endmodule

// File: rtl/emac_csr_top.sv
module emac_csr_top
  import emac_csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SIZE_W = 2,
  parameter logic [SIZE_W-1:0] WORD_SIZE = SIZE_W'(2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_err_size_o,
  output logic              rsp_err_map_o,
  input  logic [31:0]       rx_evt_i,
  input  logic [31:0]       tx_evt_i,
  input  logic [31:0]       sys_evt_i,
  input  logic [31:0]       wake_evt_i,
  input  logic [31:0]       mmc_rx_evt_i,
  input  logic [31:0]       mmc_tx_evt_i,
  output logic              sta_start_o,
  output logic              sta_write_o,
  output logic [4:0]        sta_phy_o,
  output logic [4:0]        sta_reg_o,
  output logic [15:0]       sta_wdata_o,
  input  logic              sta_done_i,
  input  logic [15:0]       sta_rdata_i,
  input  logic              sta_nophy_i,
  output logic [31:0]       mode_o,
  output logic [47:0]       mac_addr_o,
  output logic [63:0]       hash_o,
  output logic [31:0]       flow_o,
  output logic [15:0]       vlan_a_o,
  output logic [15:0]       vlan_b_o,
  output logic [31:0]       sys_ctl_o,
  output logic              counters_clear_o
);
  logic             rd_ok, wr_ok, size_bad, map_bad;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] view    [NUM_REGS];
  logic [DATA_W-1:0] set_bus [NUM_REGS];

  emac_csr_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WORD_SIZE(WORD_SIZE)) dec_i (
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_size_i(req_size_i), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .idx_o(idx),
    .size_bad_o(size_bad), .map_bad_o(map_bad)
  );

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) set_bus[k] = '0;
    set_bus[RG_WAKE_CTL]  = wake_evt_i;
    set_bus[RG_SYS_STAT]  = sys_evt_i;
    set_bus[RG_RX_STKY]   = rx_evt_i;
    set_bus[RG_TX_STKY]   = tx_evt_i;
    set_bus[RG_MMC_RIRQS] = mmc_rx_evt_i;
    set_bus[RG_MMC_TIRQS] = mmc_tx_evt_i;
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam reg_kind_e KIND = kind_of(i);
      wire sel_wr = wr_ok && (idx == IDX_W'(i));
      if (KIND == K_PLAIN) begin : g_plain
        localparam logic [DATA_W-1:0] RV = reset_value(i);
        localparam logic [DATA_W-1:0] WM = store_mask(i);
        logic [DATA_W-1:0] q_r;
        always_ff @(posedge clk) begin
          if (rst)         q_r <= RV;
          else if (sel_wr) q_r <= req_wdata_i & WM;
        end
        assign view[i] = q_r;
      end else if (KIND == K_W1C) begin : g_w1c
        logic [DATA_W-1:0] q_w;
        emac_csr_w1c_reg #(
          .W(DATA_W), .CLR_MASK(clear_mask(i)),
          .PLAIN_OTHERS(others_writable(i)), .RST_VAL(reset_value(i))
        ) reg_i (
          .clk(clk), .rst(rst), .we_i(sel_wr), .wdata_i(req_wdata_i),
          .set_i(set_bus[i]), .q_o(q_w)
        );
        assign view[i] = q_w;
      end
    end
  endgenerate

  // Frame status words: read-only to the bus, cleared on a rising enable.
  logic [DATA_W-1:0] rx_stat_q, tx_stat_q;
  wire  wr_mode  = wr_ok && (idx == IDX_W'(RG_MODE));
  wire  rx_rise  = wr_mode && !view[RG_MODE][MODE_RX_BIT] && req_wdata_i[MODE_RX_BIT];
  wire  tx_rise  = wr_mode && !view[RG_MODE][MODE_TX_BIT] && req_wdata_i[MODE_TX_BIT];
  localparam logic [DATA_W-1:0] COMP_M = DATA_W'(1) << COMP_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_stat_q <= '0;
      tx_stat_q <= '0;
    end else begin
      rx_stat_q <= (rx_stat_q & ~(rx_rise ? COMP_M : '0)) | rx_evt_i;
      tx_stat_q <= (tx_stat_q & ~(tx_rise ? COMP_M : '0)) | tx_evt_i;
    end
  end
  assign view[RG_RX_STAT] = rx_stat_q;
  assign view[RG_TX_STAT] = tx_stat_q;

  emac_csr_mgmt mgmt_i (
    .clk(clk), .rst(rst),
    .addr_we_i(wr_ok && (idx == IDX_W'(RG_MG_ADDR))),
    .data_we_i(wr_ok && (idx == IDX_W'(RG_MG_DATA))),
    .wdata_i(req_wdata_i), .sta_done_i(sta_done_i), .sta_rdata_i(sta_rdata_i),
    .sta_nophy_i(sta_nophy_i), .addr_q_o(view[RG_MG_ADDR]), .data_q_o(view[RG_MG_DATA]),
    .sta_start_o(sta_start_o), .sta_write_o(sta_write_o), .sta_phy_o(sta_phy_o),
    .sta_reg_o(sta_reg_o), .sta_wdata_o(sta_wdata_o)
  );

  // Response and strobe registers.
  logic              rsp_valid_q, err_size_q, err_map_q, clr_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      err_size_q  <= 1'b0;
      err_map_q   <= 1'b0;
      rdata_q     <= '0;
      clr_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      err_size_q  <= size_bad;
      err_map_q   <= map_bad;
      rdata_q     <= rd_ok ? view[idx] : '0;
      clr_q       <= wr_ok && (idx == IDX_W'(RG_MMC_CTL)) && req_wdata_i[0];
    end
  end

  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_err_size_o   = err_size_q;
  assign rsp_err_map_o    = err_map_q;
  assign rsp_rdata_o      = rdata_q;
  assign counters_clear_o = clr_q;

  assign mode_o     = view[RG_MODE];
  assign mac_addr_o = {view[RG_ADDR_HI][15:0], view[RG_ADDR_LO]};
  assign hash_o     = {view[RG_HASH_HI], view[RG_HASH_LO]};
  assign flow_o     = view[RG_FLOW];
  assign vlan_a_o   = view[RG_VLAN_A][15:0];
  assign vlan_b_o   = view[RG_VLAN_B][15:0];
  assign sys_ctl_o  = view[RG_SYS_CTL];

  // R1: wrong size flags a size error with zero data, never a map error
  assert_size_err_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_size_i != WORD_SIZE) |=>
      (rsp_err_size_o && !rsp_err_map_o && rsp_rdata_o == '0));

  // R2: a word access beyond the map flags a map error with zero data
  assert_map_err_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_size_i == WORD_SIZE && req_addr_i >= ADDR_W'(NUM_REGS)) |=>
      (rsp_err_map_o && !rsp_err_size_o && rsp_rdata_o == '0));

  // R3: every request is answered in the next cycle
  assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> rsp_valid_o);

  // R5: rising RX enable with no new event leaves RX complete clear
  assert_rx_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_write_i && req_size_i == WORD_SIZE && req_addr_i == ADDR_W'(RG_MODE)
     && !mode_o[MODE_RX_BIT] && req_wdata_i[MODE_RX_BIT] && !rx_evt_i[COMP_BIT])
    |=> !rx_stat_q[COMP_BIT]);

  // R10: a bit-0 write to statistics control gives a one-cycle clear strobe
  assert_clear_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_write_i && req_size_i == WORD_SIZE
     && req_addr_i == ADDR_W'(RG_MMC_CTL) && req_wdata_i[0]) |=> counters_clear_o);

  assert_clear_single_R10: assert property (@(posedge clk) disable iff (rst)
    (counters_clear_o && !(req_valid_i && req_write_i && req_wdata_i[0]))
    |=> !counters_clear_o);
endmodule

// File: tb/emac_csr_top_tb_top.sv
module emac_csr_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [5:0]  req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_wdata = '0;
  logic [31:0] rx_evt = '0, tx_evt = '0, sys_evt = '0, wake_evt = '0, mrx_evt = '0, mtx_evt = '0;
  logic        sta_done = 0, sta_nophy = 0;
  logic [15:0] sta_rdata = '0;

  logic        rsp_valid, rsp_err_size, rsp_err_map, sta_start, sta_write, counters_clear;
  logic [31:0] rsp_rdata, mode, flow, sys_ctl;
  logic [4:0]  sta_phy, sta_reg;
  logic [15:0] sta_wdata, vlan_a, vlan_b;
  logic [47:0] mac_addr;
  logic [63:0] hash;

  emac_csr_top dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_size_o(rsp_err_size),
    .rsp_err_map_o(rsp_err_map), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt), .sys_evt_i(sys_evt),
    .wake_evt_i(wake_evt), .mmc_rx_evt_i(mrx_evt), .mmc_tx_evt_i(mtx_evt),
    .sta_start_o(sta_start), .sta_write_o(sta_write), .sta_phy_o(sta_phy), .sta_reg_o(sta_reg),
    .sta_wdata_o(sta_wdata), .sta_done_i(sta_done), .sta_rdata_i(sta_rdata),
    .sta_nophy_i(sta_nophy), .mode_o(mode), .mac_addr_o(mac_addr), .hash_o(hash),
    .flow_o(flow), .vlan_a_o(vlan_a), .vlan_b_o(vlan_b), .sys_ctl_o(sys_ctl),
    .counters_clear_o(counters_clear)
  );

  int checks = 0, errors = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, updated on each rising edge from the sampled inputs.
  logic [31:0] m [32];
  logic        m_rv, m_esz, m_emap, m_start, m_clr, started = 0;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    logic [31:0] o [32];
    logic [31:0] w;
    int a;
    bit wok;
    o = m;
    if (rst) begin
      for (int k = 0; k < 32; k++) m[k] = 32'h0;
      m[1] = 32'hFFFF_FFFF; m[2] = 32'hFFFF; m[8] = 32'hFFFF; m[9] = 32'hFFFF;
      m[19] = 32'h3F00; m[27] = 32'hA;
      m_rv = 0; m_esz = 0; m_emap = 0; m_rd = 0; m_start = 0; m_clr = 0;
      started = 1;
    end else begin
      a = int'(req_addr); w = req_wdata;
      m_rv   = req_valid;
      m_esz  = req_valid && req_size != 2'b10;
      m_emap = req_valid && req_size == 2'b10 && a >= 32;
      m_rd   = (req_valid && !req_write && !m_esz && !m_emap) ? o[a] : 32'h0;
      wok    = req_valid && req_write && !m_esz && !m_emap;
      m_start = 0; m_clr = 0;
      if (wok) begin
        case (a)
          0: begin
            if (!o[0][0] && w[0]) m[21][0] = 1'b0;
            if (!o[0][1] && w[1]) m[24][0] = 1'b0;
            m[0] = w;
          end
          5: if (!o[5][0]) begin m[5] = w | 32'h1; m_start = 1; end
          6: if (!o[5][0]) m[6] = w;
          10: m[10] = (o[10] & 32'hF20 & ~w) | (w & ~32'hF20);
          20: m[20] = o[20] & ~(w & 32'hE1);
          21, 24: ;
          22, 25, 28, 30: m[a] = o[a] & ~w;
          27: begin m[27] = w & ~32'h1; m_clr = w[0]; end
          default: m[a] = w;
        endcase
      end
      m[21] |= rx_evt; m[22] |= rx_evt; m[24] |= tx_evt; m[25] |= tx_evt;
      m[20] |= sys_evt; m[10] |= wake_evt; m[28] |= mrx_evt; m[30] |= mtx_evt;
      if (o[5][0] && sta_done) begin
        m[5][0] = 1'b0;
        if (!o[5][1]) m[6] = sta_nophy ? 32'hFFFF : {16'h0, sta_rdata};
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R3 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      chk("R3 rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
      chk("R1 err_size", 64'(rsp_err_size), 64'(m_esz));
      chk("R2 err_map", 64'(rsp_err_map), 64'(m_emap));
      chk("R10 counters_clear", 64'(counters_clear), 64'(m_clr));
      chk("R11 sta_start", 64'(sta_start), 64'(m_start));
      chk("R11 sta fields", {34'h0, sta_write, sta_phy, sta_reg, sta_wdata},
          {34'h0, m[5][1], m[5][11:7], m[5][6:2], m[6][15:0]});
      chk("R13 mode", 64'(mode), 64'(m[0]));
      chk("R13 mac_addr", 64'(mac_addr), {16'h0, m[2][15:0], m[1]});
      chk("R13 hash", hash, {m[4], m[3]});
      chk("R13 flow/sysctl", {flow, sys_ctl}, {m[7], m[19]});
      chk("R13 vlan", {32'h0, vlan_a, vlan_b}, {32'h0, m[8][15:0], m[9][15:0]});
    end
  end

  // Stub management engine: answers three cycles after a start.
  int stub_cnt = 0;
  always @(negedge clk) begin
    sta_done <= 1'b0;
    if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) sta_done <= 1'b1;
    end
    if (sta_start) stub_cnt <= 3;
  end

  task automatic access(bit wr, int addr, logic [1:0] size, logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 6'(addr); req_size = size; req_wdata = data;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_size = 2'b10; req_wdata = '0;
  endtask

  task automatic wr(int addr, logic [31:0] data);
    access(1, addr, 2'b10, data);
  endtask

  task automatic rd_expect(string tag, int addr, logic [31:0] exp);
    access(0, addr, 2'b10, 32'h0);
    chk(tag, 64'(rsp_rdata), 64'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R4: reset image
    rd_expect("R4 addr_lo", 1, 32'hFFFF_FFFF);
    rd_expect("R4 addr_hi", 2, 32'h0000_FFFF);
    rd_expect("R4 vlan_a", 8, 32'h0000_FFFF);
    rd_expect("R4 vlan_b", 9, 32'h0000_FFFF);
    rd_expect("R4 sys_ctl", 19, 32'h0000_3F00);
    rd_expect("R4 mmc_ctl", 27, 32'h0000_000A);
    rd_expect("R4 hash_lo", 3, 32'h0);
    // R3: plain storage
    wr(3, 32'hA5A5_1234); wr(7, 32'h0000_0C0F); wr(23, 32'h55);
    rd_expect("R3 hash_lo", 3, 32'hA5A5_1234);
    rd_expect("R3 flow", 7, 32'h0000_0C0F);
    rd_expect("R3 rx_irqe", 23, 32'h55);
    // R2: unmapped offsets
    access(0, 40, 2'b10, 0);
    chk("R2 map flag", 64'(rsp_err_map), 64'h1);
    access(1, 33, 2'b10, 32'h1234_5678);
    rd_expect("R2 no alias write", 1, 32'hFFFF_FFFF);
    // R1: size errors take priority
    access(1, 4, 2'b01, 32'hDEAD);
    chk("R1 size flag", 64'(rsp_err_size), 64'h1);
    rd_expect("R1 no write", 4, 32'h0);
    access(0, 50, 2'b00, 0);
    chk("R1 priority", {62'h0, rsp_err_size, rsp_err_map}, 64'h2);
    // R8: status words
    @(negedge clk); rx_evt = 32'h101; tx_evt = 32'h1;
    @(negedge clk); rx_evt = 0; tx_evt = 0;
    rd_expect("R8 rx_stat", 21, 32'h101);
    rd_expect("R8 rx_stky", 22, 32'h101);
    wr(21, 32'h0);
    rd_expect("R8 rx_stat ignores write", 21, 32'h101);
    // R5: enable edges
    wr(0, 32'h1);
    rd_expect("R5 rx comp cleared", 21, 32'h100);
    @(negedge clk); rx_evt = 32'h1;
    @(negedge clk); rx_evt = 0;
    wr(0, 32'h3);
    rd_expect("R5 rx kept when already enabled", 21, 32'h101);
    rd_expect("R5 tx comp cleared", 24, 32'h0);
    // R9: clear-by-one words
    wr(22, 32'h1);
    rd_expect("R9 rx_stky", 22, 32'h100);
    @(negedge clk); mrx_evt = 32'hF0;
    @(negedge clk); mrx_evt = 0;
    wr(28, 32'h30);
    rd_expect("R9 mmc rirqs", 28, 32'hC0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 6'd28; req_wdata = 32'h80; mrx_evt = 32'h80;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wdata = 0; mrx_evt = 0;
    rd_expect("R9 set wins", 28, 32'hC0);
    // R6: wake-up control
    @(negedge clk); wake_evt = 32'h20;
    @(negedge clk); wake_evt = 0;
    wr(10, 32'h25);
    rd_expect("R6 wake mixed", 10, 32'h5);
    @(negedge clk); wake_evt = 32'hF00;
    @(negedge clk); wake_evt = 0;
    wr(10, 32'h105);
    rd_expect("R6 wake masked", 10, 32'hE05);
    // R7: system status
    @(negedge clk); sys_evt = 32'hFF;
    @(negedge clk); sys_evt = 0;
    wr(20, 32'hFFFF_FFFF);
    rd_expect("R7 sys_stat", 20, 32'h1E);
    // R10: counter clear
    wr(27, 32'h5);
    chk("R10 clear pulse", 64'(counters_clear), 64'h1);
    rd_expect("R10 bit0 reads zero", 27, 32'h4);
    // R11/R12: PHY write then reads
    wr(6, 32'h1234);
    wr(5, 32'h19E);
    chk("R11 start", 64'(sta_start), 64'h1);
    chk("R11 fields", {43'h0, sta_write, sta_phy, sta_reg, sta_wdata},
        {43'h0, 1'b1, 5'd3, 5'd7, 16'h1234});
    rd_expect("R11 busy", 5, 32'h19F);
    wr(6, 32'h5555);
    idle(4);
    rd_expect("R11 busy cleared", 5, 32'h19E);
    rd_expect("R12 write keeps data", 6, 32'h1234);
    sta_rdata = 16'hBEEF; sta_nophy = 0;
    wr(5, 32'h19C);
    idle(6);
    rd_expect("R12 read data", 6, 32'hBEEF);
    sta_nophy = 1;
    wr(5, 32'h01C);
    idle(6);
    rd_expect("R12 no phy", 6, 32'hFFFF);
    sta_nophy = 0;
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule